// File: doc/BRIEF.md
# Framebuffer Word to Pixel Unpacker

This block sits between a framebuffer fetch path and a display pipeline. It accepts 32-bit words from memory on a valid/ready input and splits each word into the pixels it contains. Modes of eight bits per pixel or fewer give a palette index, which a later palette lookup resolves. Modes of sixteen bits and above give a direct 24-bit RGB value. The block also reports how many bytes one display line takes in memory for a given column count, so a fetch engine can size its line transfers.

The pixel format, byte and pixel ordering, red/blue swap and the 16-bit mux selection are captured when a word is accepted. The pixels of that word are then produced one per handshake on the output. A parameter selects between the base variant and the newer variant. On the base variant, a 2-bit mux input chooses how the 16-bit code is read. On the newer variant, that choice comes directly from the format code.

Top module: `lcd_pix_unpack`

## Requirements
- R1: After reset, px_valid is 0 and in_ready is 1.
- R2: in_ready is 1 exactly when no word is held. A word is taken on in_valid && in_ready. From then on px_valid is 1 and in_ready is 0 until the last pixel of the word is accepted (px_valid && px_ready). While px_ready is 0, the pixel outputs hold their values.
- R3: One word gives 32, 16, 8 or 4 pixels for format codes 0, 1, 2 and 3. It gives 2 pixels for codes 4, 6 and 7, and 1 pixel for code 5. After the last pixel is accepted, px_valid falls in the next cycle.
- R4: Format codes 0 to 3 select 1, 2, 4 and 8 bits per pixel. For these codes px_is_index is 1, px_index carries the pixel value in its low bits with the upper bits 0, and px_rgb is 0.
- R5: With both order flags clear, pixel 0 is taken from the least significant bits of the word, and pixel i from bits [i*bpp +: bpp].
- R6: When be_byte is 1, the four bytes of the word are reversed before unpacking: byte 3 (bits 31:24) is read as byte 0. be_byte takes priority, and be_pix is then ignored.
- R7: When be_pix is 1 and be_byte is 0, the order of the sub-byte pixels inside each byte is reversed: the first pixel of a byte comes from its most significant bits. The flag has no effect at 8 bpp and above.
- R8: For codes 4, 6 and 7, each 16-bit pixel h is decoded as follows. In 5551, red is h[4:0], green h[9:5], blue h[14:10], and h[15] is ignored. In 565, red is h[4:0], green h[10:5], blue h[15:11]. In 444, red is h[3:0], green h[7:4], blue h[11:8]. Each channel is widened to 8 bits by repeating its top bits. px_rgb holds red in [23:16], green in [15:8] and blue in [7:0]. px_is_index and px_index are 0.
- R9: Code 5 gives one pixel per word: red from bits [7:0], green from [15:8], blue from [23:16]. Bits [31:24] are ignored.
- R10: When bgr is 1, the red and blue channels of px_rgb are exchanged.
- R11: On the base variant, code 4 is read according to mux_sel. Value 1 gives 5551. Value 3 gives 565 with red and blue exchanged whatever bgr is. Values 0 and 2 give 565 and follow bgr.
- R12: On the newer variant, code 4 is 5551 and code 6 is 565, and mux_sel has no effect.
- R13: line_bytes follows the live fmt_code. It is cols/8, cols/4 and cols/2 for codes 0, 1 and 2; cols for code 3; cols*2 for codes 4, 6 and 7; and cols*4 for code 5.
- R14: Changes to fmt_code, be_byte, be_pix, bgr or mux_sel while a word is held do not change the pixels of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_code | input | 3 | Pixel format code |
| be_byte | input | 1 | Reverse byte order within the word |
| be_pix | input | 1 | Reverse sub-byte pixel order within each byte |
| bgr | input | 1 | Exchange red and blue |
| mux_sel | input | 2 | 16-bit read selection (base variant) |
| cols | input | COLS_W | Pixels per display line |
| line_bytes | output | COLS_W+2 | Bytes per display line |
| in_word | input | 32 | Framebuffer word |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Block can take a word |
| px_valid | output | 1 | Pixel outputs are valid |
| px_ready | input | 1 | Consumer takes the pixel |
| px_is_index | output | 1 | Pixel is a palette index |
| px_index | output | 8 | Palette index |
| px_rgb | output | 24 | Direct colour, red in the top byte |

## Verification
A bad pixel counter appears at the ports in one of two ways. The word can end too early or too late, so px_valid falls at the wrong cycle and in_ready rises out of turn. Or a pixel comes from the wrong bit field, so px_index or px_rgb differs in the first cycle that pixel is shown. A wrong captured configuration shows up on the first pixel of the word as a wrong field, channel order or index flag. The bench therefore compares every pixel against its own model. It also checks px_valid and in_ready on every cycle of each word, and changes the live controls while a word is held.

// File: rtl/lcd_unpack_pkg.sv
// Shared types and helpers for the framebuffer pixel unpacker.
// Assumes 32-bit framebuffer words and at most 32 pixels per word.
package lcd_unpack_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 5;

    typedef enum logic [2:0] {
        FMT_1B  = 3'd0,
        FMT_2B  = 3'd1,
        FMT_4B  = 3'd2,
        FMT_8B  = 3'd3,
        FMT_16B = 3'd4,
        FMT_32B = 3'd5,
        FMT_565 = 3'd6,
        FMT_444 = 3'd7
    } fmt_e;

    typedef enum logic [1:0] {
        LAY_5551 = 2'd0,
        LAY_565  = 2'd1,
        LAY_444  = 2'd2,
        LAY_888  = 2'd3
    } layout_e;

    typedef struct packed {
        fmt_e    fmt;
        logic    be_byte;
        logic    be_pix;
        logic    swap_rb;
        layout_e layout;
    } cfg_t;

    // log2 of bits per pixel for a format code
    function automatic logic [2:0] fmt_log2(input fmt_e f);
        case (f)
            FMT_1B:  return 3'd0;
            FMT_2B:  return 3'd1;
            FMT_4B:  return 3'd2;
            FMT_8B:  return 3'd3;
            FMT_32B: return 3'd5;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/lcd_fmt_resolve.sv
// Resolves the colour layout and red/blue exchange from the format code,
// the BGR control and the external 16-bit mux input.
// NEWER=0 builds the base variant (mux decides code 4), NEWER=1 the newer one.
module lcd_fmt_resolve
    import lcd_unpack_pkg::*;
#(
    parameter bit NEWER = 1'b0
) (
    input  fmt_e       fmt,
    input  logic       bgr,
    input  logic [1:0] mux_sel,
    output layout_e    layout,
    output logic       swap_rb
);

    layout_e lay16;
    logic    force_swap;

    generate
        if (NEWER) begin : g_newer
            // newer variant: code 4 is always 5551, mux unused
            assign lay16      = LAY_5551;
            assign force_swap = 1'b0;
            logic unused_mux;
            assign unused_mux = ^mux_sel;
        end else begin : g_base
            // base variant: external mux picks the 16-bit reading
            always_comb begin
                lay16      = (mux_sel == 2'd1) ? LAY_5551 : LAY_565;
                force_swap = (mux_sel == 2'd3);
            end
        end
    endgenerate

    // map format code to decoder layout and swap control
    always_comb begin
        case (fmt)
            FMT_16B: layout = lay16;
            FMT_565: layout = LAY_565;
            FMT_444: layout = LAY_444;
            default: layout = LAY_888;
        endcase
        swap_rb = bgr || ((fmt == FMT_16B) && force_swap);
    end

endmodule

// File: rtl/lcd_pix_select.sv
// Picks the bit field of one pixel out of a held word, applying byte
// reversal and sub-byte pixel reversal. Output is the field shifted to bit 0.
// Assumes idx is below the pixel count of the format.
module lcd_pix_select
    import lcd_unpack_pkg::*;
#(
    parameter int FIELD_W = 24
) (
    input  logic [WORD_W-1:0] word,
    input  fmt_e              fmt,
    input  logic              be_byte,
    input  logic              be_pix,
    input  logic [CNT_W-1:0]  idx,
    output logic [FIELD_W-1:0] field
);

    logic [2:0]        lb;
    logic [WORD_W-1:0] sw;
    logic [10:0]       off_wide;
    logic [3:0]        bpp4;
    logic [2:0]        flip;
    logic [4:0]        off;

    // reorder bytes, then locate the pixel's bit offset
    always_comb begin
        lb       = fmt_log2(fmt);
        sw       = be_byte ? {word[7:0], word[15:8], word[23:16], word[31:24]} : word;
        off_wide = {6'd0, idx} << lb;
        bpp4     = 4'd1 << lb;
        flip     = (be_pix && !be_byte && (lb < 3'd3)) ? 3'(4'd8 - bpp4) : 3'd0;
        off      = off_wide[4:0] ^ {2'b00, flip};
        field    = FIELD_W'(sw >> off);
    end

endmodule

// File: rtl/lcd_color_expand.sv
// Turns a raw pixel field into either a palette index or a 24-bit RGB
// value with channels widened by top-bit replication.
module lcd_color_expand
    import lcd_unpack_pkg::*;
(
    input  logic [23:0] field,
    input  fmt_e        fmt,
    input  layout_e     layout,
    input  logic        swap_rb,
    output logic        is_index,
    output logic [7:0]  index,
    output logic [23:0] rgb
);

    logic [2:0] lb;
    logic [8:0] mask9;
    logic [7:0] r8, g8, b8;

    // decode the field by format and layout
    always_comb begin
        lb       = fmt_log2(fmt);
        mask9    = (9'd1 << (4'd1 << lb)) - 9'd1;
        is_index = (lb <= 3'd3);
        index    = 8'd0;
        r8       = 8'd0;
        g8       = 8'd0;
        b8       = 8'd0;
        if (is_index) begin
            index = field[7:0] & mask9[7:0];
        end else begin
            case (layout)
                LAY_5551: begin
                    r8 = {field[4:0],   field[4:2]};
                    g8 = {field[9:5],   field[9:7]};
                    b8 = {field[14:10], field[14:12]};
                end
                LAY_565: begin
                    r8 = {field[4:0],   field[4:2]};
                    g8 = {field[10:5],  field[10:9]};
                    b8 = {field[15:11], field[15:13]};
                end
                LAY_444: begin
                    r8 = {field[3:0],  field[3:0]};
                    g8 = {field[7:4],  field[7:4]};
                    b8 = {field[11:8], field[11:8]};
                end
                default: begin
                    r8 = field[7:0];
                    g8 = field[15:8];
                    b8 = field[23:16];
                end
            endcase
        end
        rgb = is_index ? 24'd0 : (swap_rb ? {b8, g8, r8} : {r8, g8, b8});
    end

endmodule

// File: rtl/lcd_line_size.sv
// Bytes one display line occupies for the live format code and column count.
module lcd_line_size
    import lcd_unpack_pkg::*;
#(
    parameter int COLS_W = 12
) (
    input  fmt_e              fmt,
    input  logic [COLS_W-1:0] cols,
    output logic [COLS_W+1:0] line_bytes
);

    logic [COLS_W+1:0] ext;

    // scale column count by bytes per pixel
    always_comb begin
        ext = {2'b00, cols};
        case (fmt)
            FMT_1B:  line_bytes = ext >> 3;
            FMT_2B:  line_bytes = ext >> 2;
            FMT_4B:  line_bytes = ext >> 1;
            FMT_8B:  line_bytes = ext;
            FMT_32B: line_bytes = ext << 2;
            default: line_bytes = ext << 1;
        endcase
    end

endmodule

// File: rtl/lcd_pix_unpack.sv
// Streaming framebuffer unpacker: holds one 32-bit word with the format
// controls captured on acceptance and emits its pixels one per handshake.
// Assumes a consumer that may stall at any cycle; no word is taken while
// one is held.
module lcd_pix_unpack
    import lcd_unpack_pkg::*;
#(
    parameter int COLS_W = 12,
    parameter bit NEWER  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fmt_code,
    input  logic              be_byte,
    input  logic              be_pix,
    input  logic              bgr,
    input  logic [1:0]        mux_sel,
    input  logic [COLS_W-1:0] cols,
    output logic [COLS_W+1:0] line_bytes,
    input  logic [31:0]       in_word,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              px_valid,
    input  logic              px_ready,
    output logic              px_is_index,
    output logic [7:0]        px_index,
    output logic [23:0]       px_rgb
);

    localparam int FIELD_W = 24;

    fmt_e              fmt_live;
    layout_e           lay_live;
    logic              swap_live;
    cfg_t              cfg_q;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic [CNT_W-1:0]  last_cnt;
    logic [FIELD_W-1:0] field;
    logic              dec_idx;
    logic [7:0]        dec_index;
    logic [23:0]       dec_rgb;

    assign fmt_live = fmt_e'(fmt_code);

    lcd_fmt_resolve #(.NEWER(NEWER)) u_resolve (
        .fmt     (fmt_live),
        .bgr     (bgr),
        .mux_sel (mux_sel),
        .layout  (lay_live),
        .swap_rb (swap_live)
    );

    lcd_line_size #(.COLS_W(COLS_W)) u_line (
        .fmt        (fmt_live),
        .cols       (cols),
        .line_bytes (line_bytes)
    );

    // last pixel index of the held word
    assign last_cnt = CNT_W'(5'd31 >> fmt_log2(cfg_q.fmt));

    // word capture and pixel sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            word_q <= '0;
            cfg_q  <= '0;
        end else if (!busy_q) begin
            if (in_valid) begin
                busy_q        <= 1'b1;
                cnt_q         <= '0;
                word_q        <= in_word;
                cfg_q.fmt     <= fmt_live;
                cfg_q.be_byte <= be_byte;
                cfg_q.be_pix  <= be_pix;
                cfg_q.swap_rb <= swap_live;
                cfg_q.layout  <= lay_live;
            end
        end else if (px_ready) begin
            if (cnt_q == last_cnt) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    lcd_pix_select #(.FIELD_W(FIELD_W)) u_select (
        .word    (word_q),
        .fmt     (cfg_q.fmt),
        .be_byte (cfg_q.be_byte),
        .be_pix  (cfg_q.be_pix),
        .idx     (cnt_q),
        .field   (field)
    );

    lcd_color_expand u_expand (
        .field    (field),
        .fmt      (cfg_q.fmt),
        .layout   (cfg_q.layout),
        .swap_rb  (cfg_q.swap_rb),
        .is_index (dec_idx),
        .index    (dec_index),
        .rgb      (dec_rgb)
    );

    // output gating by the held-word flag
    always_comb begin
        in_ready    = !busy_q;
        px_valid    = busy_q;
        px_is_index = busy_q && dec_idx;
        px_index    = busy_q ? dec_index : 8'd0;
        px_rgb      = busy_q ? dec_rgb : 24'd0;
    end

endmodule

// File: rtl/lcd_pix_unpack_chk.sv
// Port-level protocol and format checks for the unpacker, bound to every
// instance of the top module.
module lcd_pix_unpack_chk #(
    parameter int COLS_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        fmt_code,
    input logic [COLS_W-1:0] cols,
    input logic [COLS_W+1:0] line_bytes,
    input logic              in_valid,
    input logic              in_ready,
    input logic              px_valid,
    input logic              px_ready,
    input logic              px_is_index,
    input logic [7:0]        px_index,
    input logic [23:0]       px_rgb
);

    // R2: no word is offered while pixels are pending
    p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready != px_valid);

    // R2: accepted word yields a pixel next cycle
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> px_valid);

    // R2: stalled pixel holds its value
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_ready) |=> (px_valid && $stable(px_index)
                                     && $stable(px_rgb) && $stable(px_is_index)));

    // R3: a 32 bpp word gives exactly one pixel
    p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fmt_code == 3'd5) ##1 px_ready |=> !px_valid);

    // R4: index formats flag their pixels as indices
    p_idx_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fmt_code < 3'd4) |=> px_is_index);

    // R4: index pixels carry no colour
    p_idx_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        px_is_index |-> (px_rgb == 24'd0));

    // R8: direct-colour formats give RGB with a zero index
    p_rgb_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fmt_code >= 3'd4) |=> (!px_is_index && px_index == 8'd0));

    // R13: 8 bpp line is one byte per column, 32 bpp four
    p_line8_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_code == 3'd3) |-> (line_bytes == (COLS_W+2)'(cols)));
    p_line32_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_code == 3'd5) |-> (line_bytes == {cols, 2'b00}));

endmodule

bind lcd_pix_unpack lcd_pix_unpack_chk #(.COLS_W(COLS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_code    (fmt_code),
    .cols        (cols),
    .line_bytes  (line_bytes),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .px_valid    (px_valid),
    .px_ready    (px_ready),
    .px_is_index (px_is_index),
    .px_index    (px_index),
    .px_rgb      (px_rgb)
);

// File: tb/lcd_pix_unpack_bench.sv
// Bench: drives base and newer variants with the same stream and checks
// every pixel against a byte-level model.
module lcd_pix_unpack_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COLS_W     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        fmt_code = 3'd0;
    logic              be_byte = 1'b0, be_pix = 1'b0, bgr = 1'b0;
    logic [1:0]        mux_sel = 2'd0;
    logic [COLS_W-1:0] cols = '0;
    logic [31:0]       in_word = '0;
    logic              in_valid = 1'b0;
    logic              px_ready = 1'b0;

    logic [COLS_W+1:0] lb_a, lb_b;
    logic rdy_a, rdy_b, pv_a, pv_b, ix_a, ix_b;
    logic [7:0]  pi_a, pi_b;
    logic [23:0] pr_a, pr_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_pix_unpack #(.COLS_W(COLS_W), .NEWER(1'b0)) u_lcd_pix_unpack (
        .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .be_byte(be_byte),
        .be_pix(be_pix), .bgr(bgr), .mux_sel(mux_sel), .cols(cols),
        .line_bytes(lb_a), .in_word(in_word), .in_valid(in_valid),
        .in_ready(rdy_a), .px_valid(pv_a), .px_ready(px_ready),
        .px_is_index(ix_a), .px_index(pi_a), .px_rgb(pr_a));

    lcd_pix_unpack #(.COLS_W(COLS_W), .NEWER(1'b1)) u_lcd_pix_unpack_new (
        .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .be_byte(be_byte),
        .be_pix(be_pix), .bgr(bgr), .mux_sel(mux_sel), .cols(cols),
        .line_bytes(lb_b), .in_word(in_word), .in_valid(in_valid),
        .in_ready(rdy_b), .px_valid(pv_b), .px_ready(px_ready),
        .px_is_index(ix_b), .px_index(pi_b), .px_rgb(pr_b));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] get_byte(input logic [31:0] w, input bit rev, input int b);
        return rev ? w[(3-b)*8 +: 8] : w[b*8 +: 8];
    endfunction

    function automatic int npix(input logic [2:0] c);
        if (c < 3'd4) return 32 >> c;
        return (c == 3'd5) ? 1 : 2;
    endfunction

    // expected {is_index, index, rgb} for pixel i
    function automatic logic [32:0] model(input logic [31:0] w, input logic [2:0] c,
            input bit bb, input bit bp, input bit bg, input logic [1:0] mx,
            input bit newer, input int i);
        logic [7:0] r, g, b, by;
        logic [15:0] h;
        bit sw;
        int lay;  // 0:5551 1:565 2:444
        if (c < 3'd4) begin
            int bpp, ppb, j, sh;
            bpp = 1 << c; ppb = 8 / bpp; j = i % ppb;
            by  = get_byte(w, bb, i / ppb);
            sh  = (bp && !bb) ? (8 - (j + 1) * bpp) : (j * bpp);
            return {1'b1, 8'((by >> sh) & ((1 << bpp) - 1)), 24'd0};
        end
        sw = bg;
        if (c == 3'd5) begin
            r = get_byte(w, bb, 0); g = get_byte(w, bb, 1); b = get_byte(w, bb, 2);
        end else begin
            h = {get_byte(w, bb, 2*i + 1), get_byte(w, bb, 2*i)};
            if (c == 3'd7) lay = 2;
            else if (c == 3'd6) lay = 1;
            else if (newer) lay = 0;
            else if (mx == 2'd1) lay = 0;
            else begin lay = 1; if (mx == 2'd3) sw = 1'b1; end
            if (lay == 0) begin
                r = {h[4:0], h[4:2]}; g = {h[9:5], h[9:7]}; b = {h[14:10], h[14:12]};
            end else if (lay == 1) begin
                r = {h[4:0], h[4:2]}; g = {h[10:5], h[10:9]}; b = {h[15:11], h[15:13]};
            end else begin
                r = {h[3:0], h[3:0]}; g = {h[7:4], h[7:4]}; b = {h[11:8], h[11:8]};
            end
        end
        return {1'b0, 8'd0, sw ? {b, g, r} : {r, g, b}};
    endfunction

    // send one word and check every pixel it produces
    task automatic send_word(input logic [31:0] w, input logic [2:0] c, input bit bb,
            input bit bp, input bit bg, input logic [1:0] mx, input bit scr, input string tag);
        int n, k;
        bit r;
        logic [32:0] ea, eb;
        @(negedge clk);
        fmt_code = c; be_byte = bb; be_pix = bp; bgr = bg; mux_sel = mx; in_word = w;
        chk(rdy_a && rdy_b && !pv_a, "R2 idle ready", {rdy_a, rdy_b, pv_a}, 3'b110);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = $urandom;
        if (scr) begin
            fmt_code = 3'($urandom); be_byte = 1'($urandom); be_pix = 1'($urandom);
            bgr = 1'($urandom); mux_sel = 2'($urandom);
        end
        n = npix(c);
        k = 0;
        while (k < n) begin
            chk(pv_a && pv_b && !rdy_a && !rdy_b, "R2 busy", {pv_a, pv_b, rdy_a, rdy_b}, 4'b1100);
            ea = model(w, c, bb, bp, bg, mx, 1'b0, k);
            eb = model(w, c, bb, bp, bg, mx, 1'b1, k);
            chk({ix_a, pi_a, pr_a} == ea, {tag, " base"}, {ix_a, pi_a, pr_a}, ea);
            chk({ix_b, pi_b, pr_b} == eb, {tag, " newer"}, {ix_b, pi_b, pr_b}, eb);
            r = ($urandom % 4) != 0;
            px_ready = r;
            @(negedge clk);
            if (r) k++;
        end
        px_ready = 1'b0;
        chk(!pv_a && !pv_b && rdy_a && rdy_b, "R3 word end", {pv_a, pv_b, rdy_a, rdy_b}, 4'b0011);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [COLS_W+1:0] exp_lb;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pv_a && rdy_a && !pv_b && rdy_b, "R1 reset state", {pv_a, rdy_a, pv_b, rdy_b}, 4'b0101);

        // R13 line sizes at 640 columns
        cols = 12'd640;
        for (int c = 0; c < 8; c++) begin
            fmt_code = 3'(c);
            #1;
            case (c)
                0: exp_lb = 14'd80;   1: exp_lb = 14'd160;
                2: exp_lb = 14'd320;  3: exp_lb = 14'd640;
                5: exp_lb = 14'd2560; default: exp_lb = 14'd1280;
            endcase
            chk(lb_a == exp_lb && lb_b == exp_lb, "R13 line bytes", lb_a, exp_lb);
        end
        fmt_code = 3'd0;

        send_word(32'h8000_0001, 3'd0, 0, 0, 0, 2'd0, 0, "R5 1bpp little");
        send_word(32'hE4E4_1B1B, 3'd1, 0, 0, 0, 2'd0, 0, "R4 2bpp");
        send_word(32'h4433_2211, 3'd3, 1, 0, 0, 2'd0, 0, "R6 byte swap");
        send_word(32'h0000_00A5, 3'd2, 1, 1, 0, 2'd0, 0, "R6 priority");
        send_word(32'h0000_00A5, 3'd2, 0, 1, 0, 2'd0, 0, "R7 nibble order");
        send_word(32'h0103_0507, 3'd0, 0, 1, 0, 2'd0, 0, "R7 bit order");
        send_word(32'h4433_2211, 3'd3, 0, 1, 0, 2'd0, 0, "R7 no effect 8bpp");
        send_word(32'hFF12_3456, 3'd5, 0, 0, 0, 2'd0, 0, "R9 direct");
        send_word(32'hFF12_3456, 3'd5, 0, 0, 1, 2'd0, 0, "R10 bgr");
        send_word(32'hF81F_07E0, 3'd6, 0, 0, 0, 2'd0, 0, "R8 565");
        send_word(32'h0F0A_0A5F, 3'd7, 0, 0, 0, 2'd0, 0, "R8 444");
        for (int m = 0; m < 4; m++) begin
            send_word(32'h801F_7C00, 3'd4, 0, 0, 0, 2'(m), 0, "R11 mux");
            send_word(32'h801F_7C00, 3'd4, 0, 0, 1, 2'(m), 0, "R12 mux ignored");
        end
        send_word(32'hDEAD_BEEF, 3'd1, 0, 1, 0, 2'd0, 1, "R14 config held");
        send_word(32'h1234_ABCD, 3'd4, 1, 0, 1, 2'd3, 1, "R14 config held 16");

        for (int t = 0; t < 300; t++) begin
            send_word($urandom, 3'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 2'($urandom), 1'($urandom), "R3 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule